// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit computes the final operand address for an 8-bit processor with a 16-bit address space. The instruction decoder gives it a mode code, the bytes that follow the opcode, the address of the opcode and the two index registers, and then pulses `start`. The unit works out the address. When the mode needs a pointer held in page zero, it first reads that pointer through a byte-wide, synchronous memory port that uses a request/valid handshake. It raises `done` for one cycle, and at the same time `ea` holds the result.

The simple modes finish one cycle after `start`. These are operand-follows-opcode, page-zero, page-zero plus index, full 16-bit address with or without an index, and branch offset. The two pointer modes each read two bytes from page zero. They differ in when the index is applied. In the pre-indexed form, X is added to the page-zero byte before the pointer is read. In the post-indexed form, Y is added to the 16-bit pointer after it is read. An unknown mode code completes at once with `mode_err` set and makes no memory access.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is held, and before any `start`, the outputs `done`, `busy`, `mem_req` and `mode_err` are 0 and `ea` is 0.
- R2: Mode 0 (operand follows opcode) gives `ea` = `op_pc` + 1 modulo 65536.
- R3: Mode 1 gives `ea` = {0x00, `opnd_lo`}. Mode 2 adds X and mode 3 adds Y to `opnd_lo` modulo 256, and the high byte stays 0x00.
- R4: Mode 4 gives `ea` = {`opnd_hi`, `opnd_lo`}. Mode 5 adds X and mode 6 adds Y to that 16-bit value, with the carry passing into the high byte and the sum taken modulo 65536.
- R5: Mode 7 (pre-indexed pointer) reads address {0x00, (`opnd_lo`+X) mod 256} and then the next page-zero byte, which wraps at 0xFF. `ea` = {second byte, first byte}.
- R6: Mode 8 (post-indexed pointer) reads {0x00, `opnd_lo`} and the next page-zero byte, which wraps. `ea` = {second, first} + Y modulo 65536. X has no effect.
- R7: Mode 9 (branch) gives `ea` = `op_pc` + 2 + sign-extended `opnd_lo` modulo 65536.
- R8: Mode codes 10 to 15 raise `mode_err` together with `done`, with `ea` = 0. They make no memory read and finish one cycle after `start`.
- R9: `mem_req` stays high and `mem_addr` stays stable until `mem_valid`. `done` lasts one cycle. A `start` that arrives while `busy` is high is ignored.
- R10: Non-pointer modes raise `done` in the cycle after the `start` edge. Pointer modes raise `done` in the cycle after the edge on which the second `mem_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (sampled while idle) |
| mode | input | 4 | Addressing-mode code |
| op_pc | input | 16 | Address of the opcode byte |
| opnd_lo | input | 8 | First byte after the opcode |
| opnd_hi | input | 8 | Second byte after the opcode |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| mem_rdata | input | 8 | Read data, valid with mem_valid |
| mem_valid | input | 1 | Read data returned |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Result strobe |
| ea | output | 16 | Effective address |
| mode_err | output | 1 | Unsupported mode code |

## Verification
The assertions check on every cycle that requests hold while memory has not answered, that every pointer read stays in page zero, that `done` is a single-cycle pulse, and that an error always comes with `done` and a zero address. Only the bench scenarios can show the arithmetic of each mode. This covers wrap within page zero, carry across a page, the little-endian assembly of the pointer, the order of index-then-fetch versus fetch-then-index, the latency under slow memory, and that a `start` during a fetch has no effect.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    AM_IMM   = 4'd0,
    AM_ZP    = 4'd1,
    AM_ZPX   = 4'd2,
    AM_ZPY   = 4'd3,
    AM_ABS   = 4'd4,
    AM_ABSX  = 4'd5,
    AM_ABSY  = 4'd6,
    AM_PREX  = 4'd7,
    AM_POSTY = 4'd8,
    AM_REL   = 4'd9
  } am_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PLO  = 2'd1,
    S_PHI  = 2'd2
  } seq_e;
endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ea_addr_math.sv
module ea_addr_math
  import ea_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]      mode_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  output logic [2*DW-1:0] ea_o,
  output logic [DW-1:0]   ptr_o,
  output logic            use_ptr_o,
  output logic            post_o,
  output logic            bad_o
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] zp_x, zp_y;
  logic [AW-1:0] base, rel_off, zext_x, zext_y;

  assign zp_x    = lo_i + x_i;
  assign zp_y    = lo_i + y_i;
  assign base    = {hi_i, lo_i};
  assign rel_off = {{DW{lo_i[DW-1]}}, lo_i};
  assign zext_x  = {{DW{1'b0}}, x_i};
  assign zext_y  = {{DW{1'b0}}, y_i};

  always_comb begin
    ea_o      = '0;
    ptr_o     = '0;
    use_ptr_o = 1'b0;
    post_o    = 1'b0;
    bad_o     = 1'b0;
    case (mode_i)
      AM_IMM:   ea_o = pc_i + AW'(1);
      AM_ZP:    ea_o = {{DW{1'b0}}, lo_i};
      AM_ZPX:   ea_o = {{DW{1'b0}}, zp_x};
      AM_ZPY:   ea_o = {{DW{1'b0}}, zp_y};
      AM_ABS:   ea_o = base;
      AM_ABSX:  ea_o = base + zext_x;
      AM_ABSY:  ea_o = base + zext_y;
      AM_REL:   ea_o = pc_i + AW'(2) + rel_off;
      AM_PREX: begin
        use_ptr_o = 1'b1;
        ptr_o     = zp_x;
      end
      AM_POSTY: begin
        use_ptr_o = 1'b1;
        post_o    = 1'b1;
        ptr_o     = lo_i;
      end
      default:  bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_fetch_seq.sv
module ea_fetch_seq
  import ea_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            use_ptr_i,
  input  logic            post_i,
  input  logic            bad_i,
  input  logic [2*DW-1:0] direct_i,
  input  logic [DW-1:0]   ptr_i,
  input  logic [DW-1:0]   y_i,
  input  logic            mem_valid_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            mem_req_o,
  output logic [2*DW-1:0] mem_addr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] ea_o,
  output logic            err_o
);
  localparam int AW = 2 * DW;

  seq_e          st_q, st_d;
  logic [DW-1:0] ptr_q, ptr_d, lo_q, lo_d, y_q, y_d;
  logic          post_q, post_d;
  logic [AW-1:0] ea_q, ea_d;
  logic          done_q, done_d, err_q, err_d;
  logic          cap_en, lo_en, ea_en;
  logic [AW-1:0] post_add;

  assign post_add = post_q ? {{DW{1'b0}}, y_q} : '0;

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    lo_d   = lo_q;
    y_d    = y_q;
    post_d = post_q;
    ea_d   = ea_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    cap_en = 1'b0;
    lo_en  = 1'b0;
    ea_en  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          if (bad_i) begin
            ea_d   = '0;
            ea_en  = 1'b1;
            err_d  = 1'b1;
            done_d = 1'b1;
          end else if (use_ptr_i) begin
            st_d   = S_PLO;
            ptr_d  = ptr_i;
            post_d = post_i;
            y_d    = y_i;
            cap_en = 1'b1;
          end else begin
            ea_d   = direct_i;
            ea_en  = 1'b1;
            done_d = 1'b1;
          end
        end
      end
      S_PLO: begin
        if (mem_valid_i) begin
          lo_d   = mem_rdata_i;
          ptr_d  = ptr_q + 1'b1;
          lo_en  = 1'b1;
          cap_en = 1'b1;
          st_d   = S_PHI;
        end
      end
      S_PHI: begin
        if (mem_valid_i) begin
          ea_d   = {mem_rdata_i, lo_q} + post_add;
          ea_en  = 1'b1;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ptr_q  <= '0;
      lo_q   <= '0;
      y_q    <= '0;
      post_q <= 1'b0;
      ea_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (cap_en) begin
        ptr_q  <= ptr_d;
        y_q    <= y_d;
        post_q <= post_d;
      end
      if (lo_en) lo_q <= lo_d;
      if (ea_en) ea_q <= ea_d;
    end
  end

  assign mem_req_o  = (st_q != S_IDLE);
  assign mem_addr_o = {{DW{1'b0}}, ptr_q};
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign ea_o       = ea_q;
  assign err_o      = err_q;
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] op_pc,
  input  logic [DW-1:0] opnd_lo,
  input  logic [DW-1:0] opnd_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_valid,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          mode_err
);
  logic          rst_n_int;
  logic [AW-1:0] direct_ea;
  logic [DW-1:0] ptr_zp;
  logic          use_ptr, post_y, bad_mode;

  ea_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ea_addr_math #(.DW(DW)) u_math (
    .mode_i    (mode),
    .pc_i      (op_pc),
    .lo_i      (opnd_lo),
    .hi_i      (opnd_hi),
    .x_i       (idx_x),
    .y_i       (idx_y),
    .ea_o      (direct_ea),
    .ptr_o     (ptr_zp),
    .use_ptr_o (use_ptr),
    .post_o    (post_y),
    .bad_o     (bad_mode)
  );

  ea_fetch_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_i     (start),
    .use_ptr_i   (use_ptr),
    .post_i      (post_y),
    .bad_i       (bad_mode),
    .direct_i    (direct_ea),
    .ptr_i       (ptr_zp),
    .y_i         (idx_y),
    .mem_valid_i (mem_valid),
    .mem_rdata_i (mem_rdata),
    .mem_req_o   (mem_req),
    .mem_addr_o  (mem_addr),
    .busy_o      (busy),
    .done_o      (done),
    .ea_o        (ea),
    .err_o       (mode_err)
  );
endmodule

// File: rtl/ea_chk.sv
module ea_chk #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] ea,
  input logic          mode_err
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_page_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[AW-1:DW] == '0));

  p_err_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (done && ea == '0 && !busy));
endmodule

bind eff_addr_unit ea_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_valid (mem_valid),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .done      (done),
  .ea        (ea),
  .mode_err  (mode_err)
);

// File: tb/eff_addr_unit_tb.sv
module eff_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] op_pc = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
  logic [7:0]  mem_rdata = '0;
  logic        mem_valid = 1'b0;
  logic        mem_req, busy, done, mode_err;
  logic [15:0] mem_addr, ea;

  int checks = 0;
  int errors = 0;
  int mem_lat = 1;
  int mem_cnt = 0;
  int nrd = 0;
  logic [15:0] rd_addr [2];
  bit finished = 0;

  always #5 clk = ~clk;

  eff_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_pc(op_pc),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
    .mem_rdata(mem_rdata), .mem_valid(mem_valid), .mem_req(mem_req),
    .mem_addr(mem_addr), .busy(busy), .done(done), .ea(ea), .mode_err(mode_err)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] + 8'h40;
  endfunction

  always @(posedge clk) begin
    if (mem_req && mem_valid) begin
      if (nrd < 2) rd_addr[nrd] = mem_addr;
      nrd = nrd + 1;
    end
    if (mem_req && !mem_valid) begin
      if (mem_cnt >= mem_lat - 1) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem_fn(mem_addr);
        mem_cnt = 0;
      end else begin
        mem_cnt = mem_cnt + 1;
      end
    end else begin
      mem_valid <= 1'b0;
      if (!mem_req) mem_cnt = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  m;
    logic [15:0] pc;
    logic [7:0]  lo, hi, x, y;
    logic [15:0] ea;
    logic        err;
    logic [1:0]  nrd;
    logic [15:0] rd0;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 16'h1234, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1235, 1'b0, 2'd0, 16'h0000, 4'd2}, // R2
    '{4'd0, 16'hFFFF, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 2'd0, 16'h0000, 4'd2}, // R2 wrap
    '{4'd1, 16'h0000, 8'h80, 8'h55, 8'h11, 8'h22, 16'h0080, 1'b0, 2'd0, 16'h0000, 4'd3}, // R3
    '{4'd2, 16'h0000, 8'hF0, 8'h00, 8'h20, 8'h00, 16'h0010, 1'b0, 2'd0, 16'h0000, 4'd3}, // R3 wrap
    '{4'd3, 16'h0000, 8'h10, 8'h00, 8'h99, 8'h05, 16'h0015, 1'b0, 2'd0, 16'h0000, 4'd3}, // R3
    '{4'd4, 16'h0000, 8'h34, 8'h12, 8'h77, 8'h88, 16'h1234, 1'b0, 2'd0, 16'h0000, 4'd4}, // R4
    '{4'd5, 16'h0000, 8'hFF, 8'h12, 8'h01, 8'h00, 16'h1300, 1'b0, 2'd0, 16'h0000, 4'd4}, // R4 carry
    '{4'd6, 16'h0000, 8'hF0, 8'hFF, 8'h00, 8'h20, 16'h0010, 1'b0, 2'd0, 16'h0000, 4'd4}, // R4 wrap
    '{4'd5, 16'h0000, 8'h10, 8'h20, 8'h05, 8'h00, 16'h2015, 1'b0, 2'd0, 16'h0000, 4'd4}, // R4
    '{4'd7, 16'h0000, 8'h10, 8'h00, 8'h08, 8'h00, 16'h5958, 1'b0, 2'd2, 16'h0018, 4'd5}, // R5
    '{4'd7, 16'h0000, 8'hF8, 8'h00, 8'h07, 8'h00, 16'h403F, 1'b0, 2'd2, 16'h00FF, 4'd5}, // R5 wrap
    '{4'd8, 16'h0000, 8'h20, 8'h00, 8'h00, 8'h10, 16'h6170, 1'b0, 2'd2, 16'h0020, 4'd6}, // R6
    '{4'd8, 16'h0000, 8'hFF, 8'h00, 8'h00, 8'hFF, 16'h413E, 1'b0, 2'd2, 16'h00FF, 4'd6}, // R6 wrap
    '{4'd8, 16'h0000, 8'hBE, 8'h00, 8'h33, 8'h05, 16'h0003, 1'b0, 2'd2, 16'h00BE, 4'd6}, // R6 carry
    '{4'd9, 16'h1000, 8'h05, 8'h00, 8'h00, 8'h00, 16'h1007, 1'b0, 2'd0, 16'h0000, 4'd7}, // R7
    '{4'd9, 16'h1000, 8'h80, 8'h00, 8'h00, 8'h00, 16'h0F82, 1'b0, 2'd0, 16'h0000, 4'd7}, // R7
    '{4'd9, 16'h10F0, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h1171, 1'b0, 2'd0, 16'h0000, 4'd7}, // R7
    '{4'd12, 16'h4444, 8'h12, 8'h34, 8'h01, 8'h02, 16'h0000, 1'b1, 2'd0, 16'h0000, 4'd8}, // R8
    '{4'd15, 16'h4444, 8'h12, 8'h34, 8'h01, 8'h02, 16'h0000, 1'b1, 2'd0, 16'h0000, 4'd8}  // R8
  };

  task automatic run_op(input vec_t v, input int exp_lat, input bit poke);
    string tag;
    int lat;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    mode = v.m; op_pc = v.pc; opnd_lo = v.lo; opnd_hi = v.hi;
    idx_x = v.x; idx_y = v.y; start = 1'b1; nrd = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      if (poke && lat == 2) begin
        start = 1'b1; mode = 4'd0; op_pc = 16'hABCD; idx_y = 8'h00;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk({tag, " done"}, {31'd0, done}, 32'd1);
    chk({tag, " ea"}, {16'd0, ea}, {16'd0, v.ea});
    chk({tag, " err"}, {31'd0, mode_err}, {31'd0, v.err});
    chk({"R10 latency ", tag}, lat, exp_lat);
    chk({tag, " reads"}, nrd, {30'd0, v.nrd});
    if (v.nrd == 2 && nrd == 2) begin
      chk({tag, " first read"}, {16'd0, rd_addr[0]}, {16'd0, v.rd0});
      chk({tag, " second read"}, {16'd0, rd_addr[1]}, {24'd0, v.rd0[7:0] + 8'd1});
    end
    @(negedge clk);
    chk("R9 done single pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 mode_err", {31'd0, mode_err}, 32'd0);
    chk("R1 ea", {16'd0, ea}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {30'd0, busy, done}, 32'd0);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i], (VEC[i].nrd == 2'd2) ? 5 : 1, 1'b0);

    // R9 / R10: slow memory, requests must hold
    mem_lat = 3;
    run_op(VEC[11], 9, 1'b0);
    run_op(VEC[9], 9, 1'b0);
    mem_lat = 1;

    // R9: start during a fetch is ignored
    run_op(VEC[13], 5, 1'b1);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) cnt++;
    end
    chk("R9 no extra done after ignored start", cnt, 0);

    // R1: reset in the middle of a pointer fetch
    @(negedge clk);
    mode = 4'd8; opnd_lo = 8'h20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 busy cleared by reset", {31'd0, busy}, 32'd0);
    chk("R1 mem_req cleared by reset", {31'd0, mem_req}, 32'd0);
    chk("R1 ea cleared by reset", {16'd0, ea}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done || busy) cnt++;
    end
    chk("R1 quiet after mid-fetch reset", cnt, 0);

    run_op(VEC[0], 1, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule